// File: doc/BRIEF.md
# Ramp-Test Syndrome Accumulator

This block is the digital half of a built-in ramp test for an analog-to-digital converter. A slow linear ramp sweeps the converter's input while the block watches the stream of output codes. After a start request it pulses a ramp-reset output, then waits for the first non-zero code. That code opens the capture window, and the first full-scale code closes it.

Every captured code is written into an internal buffer, because the point that splits the window in half is not known until the window closes. A second pass then reads the buffer back. It drops the two boundary samples, which may be clipped, and adds the lower and upper halves of the interior into two sums. It also forms two signed syndromes from those sums. A later stage divides the syndromes to estimate the ramp's slope and offset.

The results and the flags are held until the next start.

Top module: `ramp_syndrome_acc`

## Requirements
- R1: A `start` pulse makes `ramp_rst` high for exactly one cycle, starting on the following cycle. The same pulse clears `done`, both error flags, `k_idx`, `sum_lo` and `sum_hi`.
- R2: After the ramp reset, zero codes are ignored. The first valid non-zero code becomes index 0 of the window.
- R3: The window closes at the first valid code equal to 2^CODE_W−1. `k_idx` reports that sample's index K.
- R4: Indices 0 and K never enter a sum. With h = floor((K−1)/2), `sum_lo` adds indices 1..h and `sum_hi` adds indices K−h..K−1. When K is even, the middle index K/2 is left out. When K < 2, both sums are 0.
- R5: `syn_d` equals `sum_hi` − `sum_lo` and `syn_t` equals `sum_hi` − 3·`sum_lo`. Both are two's-complement values, SYN_W bits wide.
- R6: `err_short` is set when the window holds fewer than 2^(CODE_W−2) samples, that is when K+1 < MIN_SAMPLES. The sums are still reported.
- R7: A valid code that would be stored at index DEPTH sets `err_ovf` and `done`. It leaves both sums and `k_idx` at 0.
- R8: Once `done` is high it stays high, with `k_idx`, the sums, the syndromes and the flags unchanged, until the next `start`. Samples that arrive meanwhile have no effect.
- R9: A `start` during a capture abandons that capture. The sequence begins again from the ramp reset.
- R10: Codes presented while `smp_valid` is low are ignored, including zero and full-scale codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin (or restart) a test sequence |
| smp_valid | input | 1 | Qualifies `smp_code` |
| smp_code | input | CODE_W | Converter output code |
| ramp_rst | output | 1 | One-cycle reset pulse to the ramp generator |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Results valid and held |
| err_ovf | output | 1 | Window longer than the buffer |
| err_short | output | 1 | Window shorter than MIN_SAMPLES |
| k_idx | output | IDX_W | Index K of the closing sample |
| sum_lo | output | ACC_W | Sum of the lower section |
| sum_hi | output | ACC_W | Sum of the upper section |
| syn_d | output | SYN_W | Signed syndrome sum_hi − sum_lo |
| syn_t | output | SYN_W | Signed syndrome sum_hi − 3·sum_lo |

## Verification
The bench sends random ramps with both odd and even K, which exercises the middle-sample rule. A design that drops the wrong middle index, or keeps it, gets the sums wrong on every even K.

Degenerate windows with K of 0, 1 and 2 would show an underflowing half-size as garbage sums. Short windows would show a misplaced threshold in `err_short`.

An over-long ramp must raise `err_ovf` rather than wrap the buffer. Samples sent after `done`, and a start in the middle of a capture, would show up as changed outputs or stale sums if they were not ignored.

Invalid cycles carrying full-scale and non-zero codes catch a design that looks at `smp_code` without `smp_valid`.

// File: rtl/ramp_syndrome_acc.sv
module ramp_syndrome_acc #(
  parameter int CODE_W      = 6,
  parameter int DEPTH       = 128,
  parameter int MIN_SAMPLES = 2 ** (CODE_W - 2),
  localparam int IDX_W      = $clog2(DEPTH),
  localparam int PTR_W      = IDX_W + 1,
  localparam int ACC_W      = CODE_W + IDX_W,
  localparam int SYN_W      = ACC_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  output logic             ramp_rst,
  output logic             busy,
  output logic             done,
  output logic             err_ovf,
  output logic             err_short,
  output logic [IDX_W-1:0] k_idx,
  output logic [ACC_W-1:0] sum_lo,
  output logic [ACC_W-1:0] sum_hi,
  output logic [SYN_W-1:0] syn_d,
  output logic [SYN_W-1:0] syn_t
);

  localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

  typedef enum logic [2:0] {ST_IDLE, ST_RRST, ST_SEEK, ST_CAPT, ST_SUM, ST_DONE} state_t;
  state_t state;

  logic [CODE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  half;
  logic              nz, full, at_end, wr_en;
  logic [ACC_W-1:0]  rd_ext;

  assign nz     = smp_code != '0;
  assign full   = smp_code == FULL;
  assign at_end = wr_ptr == PTR_W'(DEPTH);
  assign half   = (k_idx - IDX_W'(1)) >> 1;
  assign rd_ext = ACC_W'(mem[rd_idx]);
  assign wr_en  = smp_valid && !start &&
                  ((state == ST_SEEK && nz) || (state == ST_CAPT && !at_end));

  assign ramp_rst = state == ST_RRST;
  assign busy     = state inside {ST_RRST, ST_SEEK, ST_CAPT, ST_SUM};

  logic signed [SYN_W-1:0] lo_s, hi_s;
  assign lo_s  = {2'b00, sum_lo};
  assign hi_s  = {2'b00, sum_hi};
  assign syn_d = hi_s - lo_s;
  assign syn_t = hi_s - lo_s - (lo_s <<< 1);

  always_ff @(posedge clk)
    if (wr_en) mem[wr_ptr[IDX_W-1:0]] <= smp_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      err_ovf   <= 1'b0;
      err_short <= 1'b0;
      k_idx     <= '0;
      sum_lo    <= '0;
      sum_hi    <= '0;
      wr_ptr    <= '0;
      rd_idx    <= '0;
    end else if (start) begin
      state     <= ST_RRST;
      done      <= 1'b0;
      err_ovf   <= 1'b0;
      err_short <= 1'b0;
      k_idx     <= '0;
      sum_lo    <= '0;
      sum_hi    <= '0;
      wr_ptr    <= '0;
      rd_idx    <= '0;
    end else begin
      case (state)
        ST_RRST: state <= ST_SEEK;
        ST_SEEK:
          if (smp_valid && nz) begin
            wr_ptr <= PTR_W'(1);
            if (full) begin
              k_idx     <= '0;
              rd_idx    <= IDX_W'(1);
              err_short <= 1 < MIN_SAMPLES;
              state     <= ST_SUM;
            end else begin
              state <= ST_CAPT;
            end
          end
        ST_CAPT:
          if (smp_valid) begin
            if (at_end) begin
              err_ovf <= 1'b1;
              done    <= 1'b1;
              state   <= ST_DONE;
            end else begin
              wr_ptr <= wr_ptr + PTR_W'(1);
              if (full) begin
                k_idx     <= wr_ptr[IDX_W-1:0];
                rd_idx    <= IDX_W'(1);
                err_short <= (int'(wr_ptr) + 1) < MIN_SAMPLES;
                state     <= ST_SUM;
              end
            end
          end
        ST_SUM:
          if (rd_idx >= k_idx) begin
            done  <= 1'b1;
            state <= ST_DONE;
          end else begin
            if (rd_idx <= half)               sum_lo <= sum_lo + rd_ext;
            else if (rd_idx >= k_idx - half)  sum_hi <= sum_hi + rd_ext;
            rd_idx <= rd_idx + IDX_W'(1);
          end
        default: ;
      endcase
    end
  end

  p_ramp_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ramp_rst && !done && !err_ovf && !err_short);
  p_ramp_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_rst && !start |=> !ramp_rst);
  p_sums_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEEK || state == ST_CAPT) |-> sum_lo == '0 && sum_hi == '0);
  p_ovf_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf |-> done && sum_lo == '0 && sum_hi == '0 && k_idx == '0);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(sum_lo) && $stable(sum_hi) &&
                       $stable(k_idx) && $stable(err_short) && $stable(err_ovf));
  p_busy_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

endmodule

// File: tb/tb_ramp_syndrome_acc.sv
module tb_ramp_syndrome_acc;
  localparam int CODE_W = 6;
  localparam int DEPTH  = 128;
  localparam int MINS   = 2 ** (CODE_W - 2);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int ACC_W  = CODE_W + IDX_W;
  localparam int SYN_W  = ACC_W + 2;
  localparam int FS     = 2 ** CODE_W - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, smp_valid = 1'b0;
  logic [CODE_W-1:0] smp_code = '0;
  logic ramp_rst, busy, done, err_ovf, err_short;
  logic [IDX_W-1:0] k_idx;
  logic [ACC_W-1:0] sum_lo, sum_hi;
  logic [SYN_W-1:0] syn_d, syn_t;

  ramp_syndrome_acc #(.CODE_W(CODE_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid), .smp_code(smp_code),
    .ramp_rst(ramp_rst), .busy(busy), .done(done), .err_ovf(err_ovf), .err_short(err_short),
    .k_idx(k_idx), .sum_lo(sum_lo), .sum_hi(sum_hi), .syn_d(syn_d), .syn_t(syn_t));

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  int q [DEPTH + 16];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic eq(string req, string what, longint act, longint exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1; smp_valid = 1'b0;
    @(negedge clk); start = 1'b0;
    eq("R1", "ramp_rst after start", longint'(ramp_rst), 1);
    eq("R1", "done cleared", longint'(done), 0);
    eq("R1", "sums cleared", longint'(sum_lo) + longint'(sum_hi), 0);
  endtask

  task automatic send(int code, bit gaps);
    if (gaps && ($urandom % 3 == 0)) begin
      @(negedge clk); smp_valid = 1'b0;
      smp_code = ($urandom % 2) ? CODE_W'(FS) : CODE_W'(1 + $urandom % FS);  // R10 junk
    end
    @(negedge clk); smp_valid = 1'b1; smp_code = CODE_W'(code);
  endtask

  task automatic idle();
    @(negedge clk); smp_valid = 1'b0; smp_code = '0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4 * DEPTH && !done; i++) @(negedge clk);
  endtask

  task automatic run_ramp(int nz, int k, bit gaps);
    longint lo = 0, hi = 0;
    int h;
    for (int i = 0; i < k; i++) q[i] = 1 + int'($urandom % (FS - 1));
    q[k] = FS;
    for (int i = 0; i < nz; i++) send(0, gaps);          // R2 leading zeros
    for (int i = 0; i <= k; i++) send(q[i], gaps);
    idle();
    wait_done();
    if (k >= 2) begin
      h = (k - 1) / 2;
      for (int i = 1; i <= h; i++) lo += q[i];
      for (int i = k - h; i <= k - 1; i++) hi += q[i];
    end
    eq("R3", "done", longint'(done), 1);
    eq("R3", "k_idx", longint'(k_idx), k);
    eq("R4", "sum_lo", longint'(sum_lo), lo);
    eq("R4", "sum_hi", longint'(sum_hi), hi);
    eq("R5", "syn_d", longint'($signed(syn_d)), hi - lo);
    eq("R5", "syn_t", longint'($signed(syn_t)), hi - 3 * lo);
    eq("R6", "err_short", longint'(err_short), (k + 1 < MINS) ? 1 : 0);
    eq("R7", "err_ovf clear", longint'(err_ovf), 0);
  endtask

  task automatic hold_check();
    logic [ACC_W-1:0] l0 = sum_lo, h0 = sum_hi;
    logic [IDX_W-1:0] k0 = k_idx;
    logic f0 = err_short, o0 = err_ovf;
    for (int i = 0; i < 12; i++) send((i % 2) ? FS : 1 + i, 1'b0);
    idle(); idle();
    chk(done == 1'b1 && sum_lo == l0 && sum_hi == h0 && k_idx == k0 &&
        err_short == f0 && err_ovf == o0, "R8", "outputs held after done",
        longint'(sum_lo), longint'(l0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    eq("R1", "reset done", longint'(done), 0);
    eq("R1", "reset ramp_rst", longint'(ramp_rst), 0);
    rst_n = 1'b1;
    idle();

    do_start(); run_ramp(5, 40, 1'b0); hold_check();
    do_start(); run_ramp(3, 41, 1'b1);
    do_start(); run_ramp(0, 2, 1'b0);
    do_start(); run_ramp(2, 1, 1'b0);
    do_start(); run_ramp(4, 0, 1'b1);
    do_start(); run_ramp(1, MINS - 1, 1'b0);   // R6 exactly at the threshold
    do_start(); run_ramp(1, MINS - 2, 1'b0);   // R6 one below
    do_start(); run_ramp(0, DEPTH - 1, 1'b1);  // longest window that fits
    for (int t = 0; t < 8; t++) begin
      do_start(); run_ramp(int'($urandom % 6), 2 + int'($urandom % (DEPTH - 2)), 1'b1);
    end

    // R9: abort mid capture, then a fresh ramp
    do_start();
    for (int i = 0; i < 20; i++) send(1 + i, 1'b0);
    do_start(); run_ramp(2, 30, 1'b1);

    // R7: window overruns the buffer
    do_start();
    for (int i = 0; i < DEPTH + 4; i++) send(1 + (i % (FS - 1)), 1'b0);
    idle();
    eq("R7", "err_ovf", longint'(err_ovf), 1);
    eq("R7", "done on overflow", longint'(done), 1);
    eq("R7", "sums zero", longint'(sum_lo) + longint'(sum_hi), 0);
    hold_check();

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule